// File: doc/BRIEF.md
# I2C Register-Bank Target

This block lets an external I2C controller reach a bank of 8-bit registers over open-drain SDA and SCL. Both bus lines come in as plain inputs. The block drives only an SDA pull-down enable and never drives SCL. All logic runs on the system clock. Each bus line passes through a two-flop synchronizer, and every edge, START and STOP is detected in the system clock domain. The system clock must run at least eight times faster than SCL.

A transaction begins with START and an address byte made of seven address bits and a direction bit. In a write, the second byte loads the register pointer. Every later byte is stored at the pointer, and the pointer then advances. To read, the controller loads the pointer with a write, issues a repeated START and readdresses the target for reading. The target then returns consecutive registers for as long as the controller acknowledges them. The pointer wraps from the last register to register 0, and it is kept across transactions.

A local port reads any register combinationally and writes any register on a clock edge. If the bus and the local port write the same register in the same cycle, the bus write wins.

Top module: `i2c_regbank_target`

## Requirements
- R1: A START (SDA falls while SCL is high) or a repeated START restarts address reception. A STOP (SDA rises while SCL is high) returns the target to idle with SDA released. The register pointer keeps its value across START and STOP.
- R2: The target's address is `{ADDR_HI, addr_lo_i}`, where the parameter ADDR_HI supplies the upper 4 bits and the pins supply the lower 3 bits. When the first byte after START carries this address in bits 7..1, the target acknowledges. It does so by asserting sda_oe_o through the high phase of the 9th SCL clock. Bit 0 of that byte selects the direction: 0 is write, 1 is read.
- R3: After an address that does not match, the target acknowledges nothing and keeps SDA released until the next START. The registers and the pointer stay unchanged.
- R4: In a write, the byte after the address sets the pointer to its low log2(NUM_REGS) bits. Each following byte is stored in the pointed register, and the pointer then increments. Every byte is acknowledged.
- R5: In a read, the target returns the register at the pointer, most significant bit first, with each bit valid while SCL is high. The pointer increments after each byte. An ACK from the controller (SDA low on the 9th clock) starts the next register.
- R6: After a NACK from the controller on a read byte, the target keeps SDA released until the next START or STOP. The pointer does not advance again.
- R7: The pointer wraps from NUM_REGS-1 to 0, in both writes and reads.
- R8: Address 0000000 with the write bit is a general call. It is acknowledged only while gcall_en_i is 1. In that case gcall_o rises when the address byte completes and falls at the next START or STOP. The data bytes that follow are acknowledged but change no register and leave the pointer as it was. While gcall_en_i is 0, address 0 is treated as a mismatch.
- R9: loc_rdata_o shows the register selected by loc_addr_i combinationally. A cycle with loc_we_i high writes loc_wdata_i into that register at the clock edge.
- R10: After reset, sda_oe_o and gcall_o are 0 and every register holds 0x00.
- R11: sda_oe_o changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| addr_lo_i | input | 3 | Lower bits of the target address |
| gcall_en_i | input | 1 | Allows the general-call address to be acknowledged |
| gcall_o | output | 1 | A general call is in progress |
| loc_we_i | input | 1 | Local write strobe |
| loc_addr_i | input | 4 | Local register index |
| loc_wdata_i | input | 8 | Local write data |
| loc_rdata_o | output | 8 | Local read data |

## Verification
The synchronizer and the edge flop place every bus response three system cycles after the SCL or SDA edge that causes it. The bench therefore holds each SCL phase for eight cycles. It reads acknowledges and read data from SDA in the middle of each SCL high phase, well after the target has settled and before the next edge. gcall_o is checked once the address byte has finished, and again after STOP. Local reads are combinational and are sampled one nanosecond after the index changes; a local write is checked after the next clock edge. A monitor flags any change of sda_oe_o that falls in an SCL high phase.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WR,
    ST_GC,
    ST_RD,
    ST_SKIP
  } tgt_state_e;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned DEV_A_W = 7;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_prev, sda_prev, scl_s, sda_s;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_s;
      sda_prev <= sda_s;
    end
  end

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_prev;
  assign scl_fall_o = ~scl_s & scl_prev;
  // bus conditions only while SCL stays high across both samples
  assign start_o    = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_o     = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs #(
  parameter int unsigned NUM_REGS = 16,
  localparam int unsigned PTR_W = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_we_i,
  input  logic [PTR_W-1:0] bus_idx_i,
  input  logic [7:0]       bus_wdata_i,
  input  logic [PTR_W-1:0] bus_ridx_i,
  output logic [7:0]       bus_rdata_o,
  input  logic             loc_we_i,
  input  logic [PTR_W-1:0] loc_idx_i,
  input  logic [7:0]       loc_wdata_i,
  output logic [7:0]       loc_rdata_o
);
  logic [7:0] regs_q [NUM_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (bus_we_i && bus_idx_i == PTR_W'(i))      regs_q[i] <= bus_wdata_i;
        else if (loc_we_i && loc_idx_i == PTR_W'(i)) regs_q[i] <= loc_wdata_i;
      end
    end
  end

  assign bus_rdata_o = regs_q[bus_ridx_i];
  assign loc_rdata_o = regs_q[loc_idx_i];
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 16,
  parameter int unsigned ADDR_HI_W = 4,
  parameter logic [ADDR_HI_W-1:0] ADDR_HI = 'hA,
  localparam int unsigned PTR_W     = $clog2(NUM_REGS),
  localparam int unsigned ADDR_LO_W = DEV_A_W - ADDR_HI_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sda_i,
  input  logic                 scl_rise_i,
  input  logic                 scl_fall_i,
  input  logic                 start_i,
  input  logic                 stop_i,
  input  logic [ADDR_LO_W-1:0] addr_lo_i,
  input  logic                 gcall_en_i,
  input  logic [7:0]           rd_data_i,
  output logic [PTR_W-1:0]     ptr_o,
  output logic                 wr_en_o,
  output logic [PTR_W-1:0]     wr_idx_o,
  output logic [7:0]           wr_data_o,
  output logic                 sda_oe_o,
  output logic                 gcall_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);

  tgt_state_e       state_q;
  logic [3:0]       cnt_q;
  logic [7:0]       rx_q, tx_q;
  logic             ack_ph_q, mack_ph_q, mack_q;
  logic             sda_oe_q, gcall_q, wr_en_q;
  logic [PTR_W-1:0] ptr_q, wr_idx_q;
  logic [7:0]       wr_data_q;

  logic [DEV_A_W-1:0] own_addr;
  logic               hit_own, hit_gc, rx_state;

  assign own_addr = {ADDR_HI, addr_lo_i};
  assign hit_own  = (rx_q[7:1] == own_addr);
  assign hit_gc   = (rx_q[7:1] == '0) && !rx_q[0] && gcall_en_i;
  assign rx_state = (state_q == ST_ADDR) || (state_q == ST_PTR) ||
                    (state_q == ST_WR)   || (state_q == ST_GC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      ack_ph_q  <= 1'b0;
      mack_ph_q <= 1'b0;
      mack_q    <= 1'b0;
      sda_oe_q  <= 1'b0;
      gcall_q   <= 1'b0;
      ptr_q     <= '0;
      wr_en_q   <= 1'b0;
      wr_idx_q  <= '0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (stop_i) begin
        state_q   <= ST_IDLE;
        sda_oe_q  <= 1'b0;
        ack_ph_q  <= 1'b0;
        mack_ph_q <= 1'b0;
        gcall_q   <= 1'b0;
      end else if (start_i) begin
        state_q   <= ST_ADDR;
        cnt_q     <= '0;
        sda_oe_q  <= 1'b0;
        ack_ph_q  <= 1'b0;
        mack_ph_q <= 1'b0;
        gcall_q   <= 1'b0;
      end else if (ack_ph_q) begin
        // our acknowledge ends on the 9th falling edge
        if (scl_fall_i) begin
          ack_ph_q <= 1'b0;
          cnt_q    <= '0;
          if (state_q == ST_RD) begin
            tx_q     <= rd_data_i;
            sda_oe_q <= ~rd_data_i[7];
          end else begin
            sda_oe_q <= 1'b0;
          end
        end
      end else if (rx_state) begin
        if (scl_rise_i && cnt_q < 4'd8) begin
          rx_q  <= {rx_q[6:0], sda_i};
          cnt_q <= cnt_q + 4'd1;
        end
        if (scl_fall_i && cnt_q == 4'd8) begin
          unique case (state_q)
            ST_ADDR: begin
              if (hit_own) begin
                sda_oe_q <= 1'b1;
                ack_ph_q <= 1'b1;
                state_q  <= rx_q[0] ? ST_RD : ST_PTR;
              end else if (hit_gc) begin
                sda_oe_q <= 1'b1;
                ack_ph_q <= 1'b1;
                gcall_q  <= 1'b1;
                state_q  <= ST_GC;
              end else begin
                state_q  <= ST_SKIP;
              end
            end
            ST_PTR: begin
              ptr_q    <= rx_q[PTR_W-1:0];
              sda_oe_q <= 1'b1;
              ack_ph_q <= 1'b1;
              state_q  <= ST_WR;
            end
            ST_WR: begin
              wr_en_q   <= 1'b1;
              wr_idx_q  <= ptr_q;
              wr_data_q <= rx_q;
              ptr_q     <= ptr_q + 1'b1;
              sda_oe_q  <= 1'b1;
              ack_ph_q  <= 1'b1;
            end
            default: begin
              sda_oe_q <= 1'b1;
              ack_ph_q <= 1'b1;
            end
          endcase
        end
      end else if (state_q == ST_RD) begin
        if (!mack_ph_q) begin
          if (scl_rise_i && cnt_q < 4'd8) cnt_q <= cnt_q + 4'd1;
          if (scl_fall_i && cnt_q != 4'd0 && cnt_q < 4'd8) begin
            tx_q     <= {tx_q[6:0], 1'b0};
            sda_oe_q <= ~tx_q[6];
          end
          if (scl_fall_i && cnt_q == 4'd8) begin
            sda_oe_q  <= 1'b0;
            ptr_q     <= ptr_q + 1'b1;
            mack_ph_q <= 1'b1;
          end
        end else begin
          if (scl_rise_i) mack_q <= ~sda_i;
          if (scl_fall_i) begin
            mack_ph_q <= 1'b0;
            cnt_q     <= '0;
            if (mack_q) begin
              tx_q     <= rd_data_i;
              sda_oe_q <= ~rd_data_i[7];
            end else begin
              state_q  <= ST_SKIP;
            end
          end
        end
      end
    end
  end

  assign ptr_o     = ptr_q;
  assign wr_en_o   = wr_en_q;
  assign wr_idx_o  = wr_idx_q;
  assign wr_data_o = wr_data_q;
  assign sda_oe_o  = sda_oe_q;
  assign gcall_o   = gcall_q;

  AST_STOP_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (state_q == ST_IDLE) && !sda_oe_q); // R1
  AST_START_TO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i) |=> (state_q == ST_ADDR) && !sda_oe_q); // R1
  AST_SKIP_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SKIP) |-> !sda_oe_q); // R3
  AST_OE_ONLY_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_fall_i && !start_i && !stop_i) |=> $stable(sda_oe_q)); // R11
  AST_PTR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_q && wr_idx_q == LAST) |-> (ptr_q == '0)); // R7
  AST_GC_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gcall_q |-> !wr_en_q); // R8
  AST_GC_PAIRS_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gcall_q |-> (state_q == ST_GC)); // R8
endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target #(
  parameter int unsigned NUM_REGS  = 16,
  parameter int unsigned ADDR_HI_W = 4,
  parameter logic [ADDR_HI_W-1:0] ADDR_HI = 'hA,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned PTR_W     = $clog2(NUM_REGS),
  localparam int unsigned ADDR_LO_W = 7 - ADDR_HI_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe_o,
  input  logic [ADDR_LO_W-1:0] addr_lo_i,
  input  logic                 gcall_en_i,
  output logic                 gcall_o,
  input  logic                 loc_we_i,
  input  logic [PTR_W-1:0]     loc_addr_i,
  input  logic [7:0]           loc_wdata_i,
  output logic [7:0]           loc_rdata_o
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [PTR_W-1:0] ptr, wr_idx;
  logic             wr_en;
  logic [7:0]       wr_data, rd_data;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_tgt_ctrl #(
    .NUM_REGS  (NUM_REGS),
    .ADDR_HI_W (ADDR_HI_W),
    .ADDR_HI   (ADDR_HI)
  ) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .addr_lo_i  (addr_lo_i),
    .gcall_en_i (gcall_en_i),
    .rd_data_i  (rd_data),
    .ptr_o      (ptr),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data),
    .sda_oe_o   (sda_oe_o),
    .gcall_o    (gcall_o)
  );

  i2c_tgt_regs #(.NUM_REGS(NUM_REGS)) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_we_i    (wr_en),
    .bus_idx_i   (wr_idx),
    .bus_wdata_i (wr_data),
    .bus_ridx_i  (ptr),
    .bus_rdata_o (rd_data),
    .loc_we_i    (loc_we_i),
    .loc_idx_i   (loc_addr_i),
    .loc_wdata_i (loc_wdata_i),
    .loc_rdata_o (loc_rdata_o)
  );
endmodule

// File: tb/test_i2c_regbank_target.sv
`timescale 1ns/1ps
module test_i2c_regbank_target;
  localparam int NR = 16;
  localparam int Q  = 8;
  localparam logic [3:0] AHI = 4'hA;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tb_scl = 1'b1, tb_pull = 1'b0;
  logic       sda_w, sda_oe_o, gcall_o, gcall_en_i = 1'b0;
  logic [2:0] addr_lo_i = 3'b101;
  logic       loc_we_i = 1'b0;
  logic [3:0] loc_addr_i = '0;
  logic [7:0] loc_wdata_i = '0, loc_rdata_o;

  always #2 clk_i = ~clk_i;
  assign sda_w = ~(tb_pull | sda_oe_o);

  i2c_regbank_target i_i2c_regbank_target (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(tb_scl), .sda_i(sda_w),
    .sda_oe_o(sda_oe_o), .addr_lo_i(addr_lo_i), .gcall_en_i(gcall_en_i),
    .gcall_o(gcall_o), .loc_we_i(loc_we_i), .loc_addr_i(loc_addr_i),
    .loc_wdata_i(loc_wdata_i), .loc_rdata_o(loc_rdata_o)
  );

  int n_run = 0, n_fail = 0, viol = 0;
  logic [7:0] mdl [NR];
  int mptr = 0;
  logic prev_oe = 1'b0, prev_scl = 1'b1;

  // R11 monitor: SDA drive must not change during an SCL high phase
  always @(negedge clk_i) begin
    prev_oe  <= sda_oe_o;
    prev_scl <= tb_scl;
    if (rst_ni && tb_scl && prev_scl && sda_oe_o !== prev_oe) viol <= viol + 1;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [6:0] own_addr();
    return {AHI, addr_lo_i};
  endfunction

  function automatic bit exp_ack(input logic [6:0] a, input bit rw);
    if (a == own_addr()) return 1'b1;
    if (a == 7'd0 && !rw && gcall_en_i) return 1'b1;
    return 1'b0;
  endfunction

  task automatic wq();
    repeat (Q) @(negedge clk_i);
  endtask

  task automatic bus_start();
    tb_pull = 1'b0; wq(); tb_scl = 1'b1; wq(); tb_pull = 1'b1; wq(); tb_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    tb_pull = 1'b1; wq(); tb_scl = 1'b1; wq(); tb_pull = 1'b0; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      tb_pull = ~b[i]; wq(); tb_scl = 1'b1; wq(); wq(); tb_scl = 1'b0; wq();
    end
    tb_pull = 1'b0; wq(); tb_scl = 1'b1; wq(); ack = ~sda_w; wq(); tb_scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    tb_pull = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wq(); tb_scl = 1'b1; wq(); b[i] = sda_w; wq(); tb_scl = 1'b0; wq();
    end
    tb_pull = give_ack; wq(); tb_scl = 1'b1; wq(); wq(); tb_scl = 1'b0; wq();
    tb_pull = 1'b0;
  endtask

  task automatic wr_txn(input logic [6:0] a, input logic [7:0] p, input int n, input string req);
    bit ack, e, gc;
    logic [7:0] d;
    e  = exp_ack(a, 1'b0);
    gc = e && (a == 7'd0);
    bus_start();
    send_byte({a, 1'b0}, ack);
    chk(req, "address ack", ack, e);
    if (gc) chk("R8", "gcall_o after address", gcall_o, 1'b1);
    send_byte(p, ack);
    chk(req, "pointer ack", ack, e);
    if (e && !gc) mptr = p % NR;
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      send_byte(d, ack);
      chk(req, "data ack", ack, e);
      if (e && !gc) begin
        mdl[mptr] = d;
        mptr = (mptr + 1) % NR;
      end
    end
    bus_stop();
    if (gc) chk("R8", "gcall_o after STOP", gcall_o, 1'b0);
  endtask

  task automatic rd_body(input int n, input string req);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b);
      chk(req, "read data", b, mdl[mptr]);
      mptr = (mptr + 1) % NR;
    end
  endtask

  task automatic rd_txn(input logic [7:0] p, input int n, input string req);
    bit ack;
    bus_start();
    send_byte({own_addr(), 1'b0}, ack);
    chk(req, "address ack", ack, 1'b1);
    send_byte(p, ack);
    chk(req, "pointer ack", ack, 1'b1);
    mptr = p % NR;
    bus_start();
    send_byte({own_addr(), 1'b1}, ack);
    chk("R1", "read address ack after repeated START", ack, 1'b1);
    rd_body(n, req);
    bus_stop();
  endtask

  task automatic loc_check_all(input string req);
    for (int i = 0; i < NR; i++) begin
      @(negedge clk_i); loc_addr_i = 4'(i); #1;
      chk(req, "local read", loc_rdata_o, mdl[i]);
    end
  endtask

  task automatic loc_write(input int idx, input logic [7:0] d);
    @(negedge clk_i); loc_we_i = 1'b1; loc_addr_i = 4'(idx); loc_wdata_i = d;
    @(negedge clk_i); loc_we_i = 1'b0;
    mdl[idx] = d;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] b;
    void'($urandom(32'h5eed_1c2b));
    for (int i = 0; i < NR; i++) mdl[i] = 8'h00;
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);

    chk("R10", "sda_oe_o after reset", sda_oe_o, 1'b0);
    chk("R10", "gcall_o after reset", gcall_o, 1'b0);
    loc_check_all("R10");

    // R9 local port
    loc_write(3, 8'h5A);
    loc_write(9, 8'hC3);
    loc_check_all("R9");

    // R4 sequential write, R2 address match
    wr_txn(own_addr(), 8'h02, 3, "R4");
    loc_check_all("R4");
    // R5 read back with repeated START
    rd_txn(8'h02, 3, "R5");

    // R1 pointer retained across STOP: plain read continues at current pointer
    bus_start();
    send_byte({own_addr(), 1'b1}, ack);
    chk("R1", "address ack", ack, 1'b1);
    rd_body(2, "R1");
    bus_stop();
    chk("R1", "sda_oe_o after STOP", sda_oe_o, 1'b0);

    // R7 wrap on write and read; pointer byte upper bits ignored
    wr_txn(own_addr(), 8'hF0 | 8'(NR - 2), 4, "R7");
    loc_check_all("R7");
    rd_txn(8'(NR - 1), 3, "R7");

    // R3 mismatched address
    wr_txn(own_addr() ^ 7'h01, 8'h00, 2, "R3");
    loc_check_all("R3");

    // R8 general call disabled, then enabled
    gcall_en_i = 1'b0;
    wr_txn(7'd0, 8'h04, 2, "R8");
    gcall_en_i = 1'b1;
    wr_txn(7'd0, 8'h04, 2, "R8");
    loc_check_all("R8");
    gcall_en_i = 1'b0;

    // R6 NACK then target stays released
    rd_txn(8'h05, 1, "R6");
    bus_start();
    send_byte({own_addr(), 1'b1}, ack);
    chk("R6", "address ack", ack, 1'b1);
    recv_byte(1'b0, b);
    chk("R6", "read data before NACK", b, mdl[mptr]);
    mptr = (mptr + 1) % NR;
    recv_byte(1'b0, b);
    chk("R6", "SDA after NACK", b, 8'hFF);
    bus_stop();
    bus_start();
    send_byte({own_addr(), 1'b1}, ack);
    rd_body(1, "R6");
    bus_stop();

    // R2 new low address bits from pins
    addr_lo_i = 3'b010;
    wr_txn({AHI, 3'b101}, 8'h00, 1, "R2");
    wr_txn(own_addr(), 8'h0B, 2, "R2");
    rd_txn(8'h0B, 2, "R2");

    // random mix
    for (int t = 0; t < 14; t++) begin
      int op, n;
      logic [7:0] p;
      op = $urandom % 3;
      n  = 1 + ($urandom % 4);
      p  = 8'($urandom);
      if (op == 0) wr_txn(own_addr(), p, n, "R4");
      else if (op == 1) rd_txn(p, n, "R5");
      else loc_write($urandom % NR, 8'($urandom));
    end
    loc_check_all("R9");

    chk("R11", "sda_oe_o changes during SCL high", viol, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule